// File: doc/BRIEF.md
# Consumer Infrared Code Transmitter

This block drives the LED of a consumer remote-control link. It pulls code bytes from a show-ahead transmit FIFO and turns each byte into timed output levels. In raw mode a byte is eight serial bits. In run-length mode a byte is one level held for a number of bit periods. The active level is gated by a sub-carrier of 50% duty cycle. One programmable divisor sets the bit period and a second one sets the carrier half period.

A transmission starts when the block is idle, no under-run is pending and the FIFO holds a byte. Each FIFO entry carries two tag bits: an end-of-transmission mark written by software, and a terminal-count mark from a DMA engine. Either tag makes its byte the last one. If the FIFO is empty when a byte finishes and that byte carried no tag, the block stops and raises a sticky under-run flag. No new transmission begins until software clears that flag.

Top module: `cir_tx`

## Requirements
- R1: In raw mode (`mode_rl`=0) a byte is sent least significant bit first as 8 bits. A 1 bit gives the carrier-gated output and a 0 bit holds `led_out` low. Each bit lasts `baud_div`+1 clock cycles.
- R2: In run-length mode (`mode_rl`=1) byte bit 7 is the output level. Bits 6:0 hold the run length minus one, counted in bit periods of `baud_div`+1 cycles.
- R3: When the block is idle, `urun` is low and `fifo_empty` is low, `fifo_pop` is asserted for one cycle. The first output cycle of the byte follows that clock edge.
- R4: A byte whose `fifo_eot` tag is set is the last byte. `busy` falls in the cycle after its final bit period, and no further byte is popped.
- R5: A byte whose `fifo_tc` tag is set also ends the transmission, in the same way as R4.
- R6: If a byte without a tag finishes while `fifo_empty` is high, the transmission stops and `urun` is set in the cycle after its final bit period.
- R7: While `urun` is set, no byte is popped and no output is produced. A one-cycle `urun_clr` pulse clears `urun`, after which a transmission can start.
- R8: The sub-carrier restarts high at the first cycle of every transmission. It then alternates between `car_div`+1 cycles high and `car_div`+1 cycles low, and keeps its phase across the byte boundaries inside one transmission.
- R9: The next byte is popped in the final cycle of the current byte when the FIFO is not empty, so consecutive bytes leave no gap.
- R10: `led_out` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rl | input | 1 | 0: raw bit string, 1: run-length bytes |
| baud_div | input | BAUD_W | Bit period minus one, in clocks |
| car_div | input | CAR_W | Carrier half period minus one, in clocks |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | DATA_W | Code byte at the FIFO head |
| fifo_eot | input | 1 | End-of-transmission tag of the head byte |
| fifo_tc | input | 1 | DMA terminal-count tag of the head byte |
| fifo_pop | output | 1 | Consume the head byte |
| urun_clr | input | 1 | Clear the under-run flag |
| led_out | output | 1 | Modulated LED drive |
| busy | output | 1 | A transmission is in progress |
| urun | output | 1 | Sticky under-run flag |

## Verification
The bench sweeps small bit and carrier divisors in both byte modes. It compares `led_out` cycle by cycle against a waveform built arithmetically from the bytes, so any error in bit order, in run length or in the off-by-one of a divisor shows up as a mismatched cycle. Multi-byte streams expose a design that leaves a gap between bytes or restarts the carrier at each byte. Single-byte streams catch a carrier whose phase carries over from an earlier transmission. Untagged streams must end in an under-run; a design that drops the flag or keeps popping after it would drain the follow-up byte that the bench leaves waiting in the FIFO. The terminal-count and end tags are each exercised alone, which catches a design that honours only one of them.

// File: rtl/cir_tx.sv
module cir_tx #(
  parameter int BAUD_W = 16,
  parameter int CAR_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rl,
  input  logic [BAUD_W-1:0] baud_div,
  input  logic [CAR_W-1:0]  car_div,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_eot,
  input  logic              fifo_tc,
  output logic              fifo_pop,
  input  logic              urun_clr,
  output logic              led_out,
  output logic              busy,
  output logic              urun
);
  localparam int LEN_W = DATA_W - 1;

  logic              busy_q, urun_q, rl_q, last_q, car_q;
  logic [DATA_W-1:0] sh_q;
  logic [BAUD_W-1:0] bcnt;
  logic [LEN_W-1:0]  ucnt;
  logic [CAR_W-1:0]  ccnt;

  logic bit_end, byte_end, start, chain, under, cur_lvl;

  assign bit_end  = busy_q && (bcnt == baud_div);
  assign byte_end = bit_end && (ucnt == '0);
  assign start    = !busy_q && !urun_q && !fifo_empty;
  assign chain    = byte_end && !last_q && !fifo_empty;
  assign under    = byte_end && !last_q && fifo_empty;
  assign fifo_pop = start || chain;
  assign cur_lvl  = rl_q ? sh_q[DATA_W-1] : sh_q[0];
  assign led_out  = busy_q && cur_lvl && car_q;
  assign busy     = busy_q;
  assign urun     = urun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rl_q   <= 1'b0;
      last_q <= 1'b0;
      sh_q   <= '0;
      bcnt   <= '0;
      ucnt   <= '0;
    end else if (fifo_pop) begin
      busy_q <= 1'b1;
      rl_q   <= mode_rl;
      last_q <= fifo_eot || fifo_tc;
      sh_q   <= fifo_data;
      bcnt   <= '0;
      ucnt   <= mode_rl ? fifo_data[LEN_W-1:0] : LEN_W'(DATA_W - 1);
    end else if (byte_end) begin
      busy_q <= 1'b0;
    end else if (bit_end) begin
      bcnt <= '0;
      ucnt <= ucnt - 1'b1;
      if (!rl_q) sh_q <= sh_q >> 1;
    end else if (busy_q) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt  <= '0;
      car_q <= 1'b0;
    end else if (start) begin
      ccnt  <= '0;
      car_q <= 1'b1;
    end else if (busy_q) begin
      if (ccnt == car_div) begin
        ccnt  <= '0;
        car_q <= !car_q;
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        urun_q <= 1'b0;
    else if (under)    urun_q <= 1'b1;
    else if (urun_clr) urun_q <= 1'b0;
  end

  p_dark_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !led_out);
  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    urun |-> !fifo_pop || busy);
  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    urun && !urun_clr |=> urun);
  p_last_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && last_q |=> !busy && !urun_q == !$past(urun_q));
  p_carrier_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> led_out == cur_lvl);
endmodule

// File: tb/tb_cir_tx.sv
module tb_cir_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rl = 1'b0;
  logic [15:0] baud_div = '0;
  logic [7:0]  car_div = '0;
  logic        urun_clr = 1'b0;
  logic        fifo_pop, led_out, busy, urun;
  logic        fifo_empty, fifo_eot, fifo_tc;
  logic [7:0]  fifo_data;

  logic [7:0] fd [0:63];
  logic       fe [0:63];
  logic       ft [0:63];
  int rd = 0, wr = 0;
  int nchk = 0, nerr = 0;
  logic [7:0] pat [0:7];
  logic expv [0:8191];

  always #2.5 clk = !clk;

  assign fifo_empty = (rd == wr);
  assign fifo_data  = fd[rd[5:0]];
  assign fifo_eot   = fe[rd[5:0]];
  assign fifo_tc    = ft[rd[5:0]];

  always @(posedge clk) if (fifo_pop) rd <= rd + 1;

  cir_tx dut (
    .clk(clk), .rst_n(rst_n), .mode_rl(mode_rl), .baud_div(baud_div),
    .car_div(car_div), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_eot(fifo_eot), .fifo_tc(fifo_tc), .fifo_pop(fifo_pop),
    .urun_clr(urun_clr), .led_out(led_out), .busy(busy), .urun(urun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic e, input logic t);
    fd[wr[5:0]] = d; fe[wr[5:0]] = e; ft[wr[5:0]] = t;
    wr = wr + 1;
  endtask

  // term: 0 end tag (R4), 1 terminal count (R5), 2 none -> under-run (R6)
  task automatic xmit(input int n, input int term, input string req);
    int t, bad, first_k, first_a, p, c;
    t = 0; bad = 0; first_k = 0; first_a = 0;
    p = int'(baud_div) + 1;
    c = int'(car_div) + 1;
    for (int b = 0; b < n; b++) begin
      if (!mode_rl) begin
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < p; j++) begin expv[t] = pat[b][i]; t++; end
      end else begin
        for (int j = 0; j < (int'(pat[b][6:0]) + 1) * p; j++) begin
          expv[t] = pat[b][7]; t++;
        end
      end
    end
    for (int k = 0; k < t; k++) expv[k] = expv[k] & (((k / c) % 2) == 0);
    @(negedge clk);
    for (int b = 0; b < n; b++)
      push(pat[b], (term == 0) && (b == n - 1), (term == 1) && (b == n - 1));
    @(posedge clk);
    for (int k = 0; k < t; k++) begin
      @(negedge clk);
      if (led_out !== expv[k] || busy !== 1'b1) begin
        if (bad == 0) begin first_k = k; first_a = int'(led_out); end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("waveform R8 R9 first bad cycle %0d led", first_k),
        first_a, bad == 0 ? first_a : int'(expv[first_k]));
    @(negedge clk);
    chk(busy == 1'b0, term == 2 ? "R6" : (term == 1 ? "R5" : "R4"), "busy after end",
        int'(busy), 0);
    chk(urun == (term == 2), term == 2 ? "R6" : "R4", "urun after end", int'(urun),
        int'(term == 2));
    chk(led_out == 1'b0, "R10", "led idle", int'(led_out), 0);
    chk(rd == wr, "R9", "fifo drained", rd, wr);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && urun == 1'b0, "R3", "reset busy/urun", int'({busy, urun}), 0);
    chk(led_out == 1'b0 && fifo_pop == 1'b0, "R10", "reset led/pop",
        int'({led_out, fifo_pop}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int bd = 0; bd < 3; bd++)
      for (int cd = 0; cd < 3; cd++) begin
        baud_div = 16'(bd); car_div = 8'(cd);
        mode_rl = 1'b0;
        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF;
        xmit(3, 0, "R1");
        pat[0] = 8'h01; pat[1] = 8'h80;
        xmit(2, 1, "R1");
        mode_rl = 1'b1;
        pat[0] = 8'h82; pat[1] = 8'h01; pat[2] = 8'h85; pat[3] = 8'h80;
        xmit(4, 0, "R2");
        pat[0] = 8'h8A;
        xmit(1, 1, "R2");
      end

    baud_div = 16'd0; car_div = 8'd1; mode_rl = 1'b1;
    pat[0] = 8'hFF; pat[1] = 8'h7F; pat[2] = 8'h80;
    xmit(3, 0, "R2");

    for (int m = 0; m < 2; m++) begin
      mode_rl = m[0]; baud_div = 16'd1; car_div = 8'd2;
      pat[0] = 8'h96; pat[1] = 8'h83;
      xmit(2, 2, "R6");
      @(negedge clk);
      push(8'hFF, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      chk(rd == wr - 1, "R7", "byte held while urun", wr - rd, 1);
      chk(busy == 1'b0 && led_out == 1'b0, "R7", "silent while urun",
          int'({busy, led_out}), 0);
      rd = wr;
      urun_clr = 1'b1;
      @(negedge clk);
      urun_clr = 1'b0;
      chk(urun == 1'b0, "R7", "urun cleared", int'(urun), 0);
      pat[0] = 8'h5A;
      xmit(1, 0, "R7");
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule